// File: doc/BRIEF.md
# Paced Video Port Output Formatter

This block turns an internal pixel stream, delivered over a valid/ready handshake with start/end-of-line and start/end-of-frame tags, into a parallel video output port. Each output pixel transfer is marked by a one-cycle strobe that is synchronous to the functional clock. Alongside the strobe the port carries four one-strobe markers (first pixel of frame, last pixel of frame, first pixel of line, last pixel of line) and a 32-bit data bus made of two 16-bit lanes.

A width-mode input selects one pixel per strobe (lower lane only) or two pixels per strobe, where an even-column pixel and the odd-column pixel after it share one strobe. Three configuration inputs throttle the output: a minimum spacing between consecutive strobes, a minimum horizontal blanking after each line, and an additional vertical blanking after each frame. The downstream side cannot stall the port; all holding happens by withdrawing input ready. Configuration is expected to stay constant while a frame is in flight.

Top module: `vid_port_fmt`

## Requirements
- R1: During and after synchronous active-low reset, with no input, the strobe, all four markers and the data bus are low, and input ready is high.
- R2: In single-pixel mode every accepted pixel produces exactly one strobe, one clock after its acceptance, carrying the pixel on bits [15:0] with bits [31:16] at zero.
- R3: In dual-pixel mode an even-column pixel (column 0, 2, ...) is carried on bits [15:0] and the following odd-column pixel on bits [31:16] of the same strobe, one clock after the odd pixel is accepted.
- R4: A pixel narrower than 16 bits (12 bits by default) is right-aligned in its lane and the lane's upper bits are zero.
- R5: The frame-start marker is high only on the strobe carrying the first pixel of a frame, and the frame-end marker only on the strobe carrying the last pixel of a frame.
- R6: The line-start marker is high on the strobe carrying each line's first pixel, and the line-end marker on the strobe carrying each line's last pixel.
- R7: With a spacing setting P, two consecutive strobes are at least max(P,1) clock cycles apart; with a continuously valid input they are exactly that far apart (at least 2 for a pixel pair).
- R8: After a strobe with the line-end marker and without the frame-end marker, at least H idle cycles (the horizontal blanking setting) pass before the next strobe; with continuous input the gap is exactly max(P, H+1), and at least 2 for a pair.
- R9: After a strobe with the frame-end marker, at least H+V idle cycles (horizontal plus vertical blanking settings) pass before the next strobe.
- R10: In dual-pixel mode a line with an odd pixel count sends its last pixel alone on bits [15:0], with bits [31:16] at zero and the line-end marker set.
- R11: Input ready is low in every cycle in which spacing or blanking forbids a strobe, except in dual-pixel mode for an even-column pixel that is not the end of its line, which is parked internally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dual | input | 1 | 1 = two pixels per strobe, 0 = one pixel per strobe |
| cfg_pace | input | 17 | Minimum clock cycles between strobes (0 and 1 mean every cycle) |
| cfg_hblank | input | 8 | Minimum idle cycles after a line's last strobe |
| cfg_vblank | input | 6 | Extra idle cycles after a frame's last strobe |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block accepts the input pixel this cycle |
| in_pix | input | PIX_W | Input pixel value |
| in_sof | input | 1 | Pixel is the first of a frame (also first of its line) |
| in_sol | input | 1 | Pixel is the first of a line |
| in_eol | input | 1 | Pixel is the last of a line |
| in_eof | input | 1 | Pixel is the last of a frame (also last of its line) |
| out_stb | output | 1 | One-cycle pixel strobe |
| out_vs | output | 1 | Frame-start marker |
| out_ve | output | 1 | Frame-end marker |
| out_hs | output | 1 | Line-start marker |
| out_he | output | 1 | Line-end marker |
| out_data | output | 32 | Two 16-bit pixel lanes |

## Verification
A wrong spacing or blanking counter shows up as a strobe arriving one or more cycles early or late relative to the previous one, so the bench measures every inter-strobe gap against the value derived from the settings and flags the first strobe that misses. A corrupted parking register in dual mode shows on the very next strobe as a wrong lower lane or a misplaced line/frame marker, and a stuck parity state turns pairs into lone pixels, visible as a nonzero-versus-zero upper lane within one line. Ready that fails to drop while the spacing counter runs is seen as extra strobes and a stall count that differs from the expected number.

// File: rtl/vpf_pkg.sv
// Shared widths and the input tag type for the paced video port formatter.
package vpf_pkg;
    localparam int LANE_W = 16;
    localparam int BUS_W  = 2 * LANE_W;
    localparam int PACE_W = 17;
    localparam int HBLK_W = 8;
    localparam int VBLK_W = 6;
    localparam int BLK_W  = ((HBLK_W > VBLK_W) ? HBLK_W : VBLK_W) + 1;

    typedef struct packed {
        logic sof;
        logic sol;
        logic eol;
        logic eof;
    } vpf_tag_t;
endpackage

// File: rtl/vpf_gap_timer.sv
// Down-counting gap timer. A load sets the count; the timer reports busy
// until the count has run down to zero, one step per clock.
// Assumes: load_val of zero means "no hold".
module vpf_gap_timer #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);
    logic [CNT_W-1:0] cnt_q;

    // Reload on request, otherwise count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Busy while any hold time remains.
    always_comb begin
        busy = (cnt_q != '0);
    end
endmodule

// File: rtl/vpf_packer.sv
// Pixel packer and output register stage. In single mode each accepted
// pixel is emitted at once; in dual mode an even-column pixel is parked
// and emitted together with the following odd-column pixel, unless it
// ends the line, in which case it leaves alone.
// Assumes: input tags are well formed (sof implies sol, eof implies eol)
// and cfg_dual does not change in the middle of a line.
module vpf_packer
    import vpf_pkg::*;
#(
    parameter int PIX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_dual,
    input  logic             gate_open,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pix,
    input  vpf_tag_t         in_tag,
    output logic             in_ready,
    output logic             emit,
    output logic             emit_eol,
    output logic             emit_eof,
    output logic             out_stb,
    output logic             out_vs,
    output logic             out_ve,
    output logic             out_hs,
    output logic             out_he,
    output logic [BUS_W-1:0] out_data
);
    logic             hold_q;
    logic [PIX_W-1:0] hold_pix_q;
    logic             hold_sof_q;
    logic             hold_sol_q;
    logic             park_ok;
    logic             take;
    logic             park;

    function automatic logic [LANE_W-1:0] to_lane(input logic [PIX_W-1:0] p);
        return LANE_W'(p);
    endfunction

    // Handshake: parking needs no strobe slot, emitting does.
    always_comb begin
        park_ok  = cfg_dual & ~hold_q & ~in_tag.eol;
        in_ready = gate_open | park_ok;
        take     = in_valid & in_ready;
        park     = take & park_ok;
        emit     = take & ~park_ok;
        emit_eol = emit & in_tag.eol;
        emit_eof = emit & in_tag.eof;
    end

    // Park the even-column pixel and its start markers until its partner arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q     <= 1'b0;
            hold_pix_q <= '0;
            hold_sof_q <= 1'b0;
            hold_sol_q <= 1'b0;
        end else if (park) begin
            hold_q     <= 1'b1;
            hold_pix_q <= in_pix;
            hold_sof_q <= in_tag.sof;
            hold_sol_q <= in_tag.sol;
        end else if (emit) begin
            hold_q     <= 1'b0;
        end
    end

    // Output register: strobe, markers and lanes for one transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_stb  <= 1'b0;
            out_vs   <= 1'b0;
            out_ve   <= 1'b0;
            out_hs   <= 1'b0;
            out_he   <= 1'b0;
            out_data <= '0;
        end else if (emit && hold_q) begin
            out_stb  <= 1'b1;
            out_vs   <= hold_sof_q;
            out_hs   <= hold_sol_q;
            out_ve   <= in_tag.eof;
            out_he   <= in_tag.eol;
            out_data <= {to_lane(in_pix), to_lane(hold_pix_q)};
        end else if (emit) begin
            out_stb  <= 1'b1;
            out_vs   <= in_tag.sof;
            out_hs   <= in_tag.sol;
            out_ve   <= in_tag.eof;
            out_he   <= in_tag.eol;
            out_data <= {{LANE_W{1'b0}}, to_lane(in_pix)};
        end else begin
            out_stb  <= 1'b0;
            out_vs   <= 1'b0;
            out_hs   <= 1'b0;
            out_ve   <= 1'b0;
            out_he   <= 1'b0;
            out_data <= '0;
        end
    end

    // R2
    single_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stb && !cfg_dual) |-> (out_data[BUS_W-1:LANE_W] == '0));

    generate
        if (PIX_W < LANE_W) begin : g_pad_chk
            // R4
            lane_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_stb |-> ((out_data[LANE_W-1:PIX_W] == '0) &&
                             (out_data[BUS_W-1:LANE_W+PIX_W] == '0)));
        end
    endgenerate
endmodule

// File: rtl/vid_port_fmt.sv
// Paced video port output formatter, top level. Combines the packer with
// a strobe-spacing timer and a blanking timer; a strobe may only be issued
// when both timers have run out. No stall input exists on the output side.
// Assumes: configuration inputs are static while a frame is being sent.
module vid_port_fmt
    import vpf_pkg::*;
#(
    parameter int PIX_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dual,
    input  logic [PACE_W-1:0] cfg_pace,
    input  logic [HBLK_W-1:0] cfg_hblank,
    input  logic [VBLK_W-1:0] cfg_vblank,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_pix,
    input  logic              in_sof,
    input  logic              in_sol,
    input  logic              in_eol,
    input  logic              in_eof,
    output logic              out_stb,
    output logic              out_vs,
    output logic              out_ve,
    output logic              out_hs,
    output logic              out_he,
    output logic [BUS_W-1:0]  out_data
);
    vpf_tag_t          tag;
    logic              emit;
    logic              emit_eol;
    logic              emit_eof;
    logic              pace_busy;
    logic              blank_busy;
    logic              gate_open;
    logic [PACE_W-1:0] pace_load;
    logic [BLK_W-1:0]  blank_load;

    // Bundle the input tags and derive the timer reload values.
    always_comb begin
        tag        = '{sof: in_sof, sol: in_sol, eol: in_eol, eof: in_eof};
        pace_load  = (cfg_pace > PACE_W'(1)) ? (cfg_pace - 1'b1) : '0;
        blank_load = BLK_W'(cfg_hblank) + (emit_eof ? BLK_W'(cfg_vblank) : '0);
        gate_open  = ~pace_busy & ~blank_busy;
    end

    vpf_gap_timer #(.CNT_W(PACE_W)) u_pace (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (emit),
        .load_val (pace_load),
        .busy     (pace_busy)
    );

    vpf_gap_timer #(.CNT_W(BLK_W)) u_blank (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (emit_eol),
        .load_val (blank_load),
        .busy     (blank_busy)
    );

    vpf_packer #(.PIX_W(PIX_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_dual  (cfg_dual),
        .gate_open (gate_open),
        .in_valid  (in_valid),
        .in_pix    (in_pix),
        .in_tag    (tag),
        .in_ready  (in_ready),
        .emit      (emit),
        .emit_eol  (emit_eol),
        .emit_eof  (emit_eof),
        .out_stb   (out_stb),
        .out_vs    (out_vs),
        .out_ve    (out_ve),
        .out_hs    (out_hs),
        .out_he    (out_he),
        .out_data  (out_data)
    );

    // R7
    pace_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stb && (cfg_pace > PACE_W'(1))) |=> !out_stb);

    // R8
    hblank_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stb && out_he && (cfg_hblank != '0)) |=> !out_stb);

    // R11
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pace_busy && !cfg_dual) |-> !(in_valid && in_ready));
endmodule

// File: tb/tb_vid_port_fmt.sv
`timescale 1ns/1ps
module tb_vid_port_fmt;
    localparam int PIX_W = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_dual = 1'b0;
    logic [16:0] cfg_pace = '0;
    logic [7:0]  cfg_hblank = '0;
    logic [5:0]  cfg_vblank = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [PIX_W-1:0] in_pix = '0;
    logic        in_sof = 1'b0, in_sol = 1'b0, in_eol = 1'b0, in_eof = 1'b0;
    logic        out_stb, out_vs, out_ve, out_hs, out_he;
    logic [31:0] out_data;

    int n_chk = 0, n_fail = 0, cyc = 0, stall_cnt = 0;
    bit mon_on = 1'b0;
    logic [31:0] m_d[$];
    logic [3:0]  m_f[$];
    int          m_t[$];

    always #4 clk = ~clk;

    vid_port_fmt #(.PIX_W(PIX_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_pace(cfg_pace),
        .cfg_hblank(cfg_hblank), .cfg_vblank(cfg_vblank), .in_valid(in_valid),
        .in_ready(in_ready), .in_pix(in_pix), .in_sof(in_sof), .in_sol(in_sol),
        .in_eol(in_eol), .in_eof(in_eof), .out_stb(out_stb), .out_vs(out_vs),
        .out_ve(out_ve), .out_hs(out_hs), .out_he(out_he), .out_data(out_data)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: record every strobe away from the clock edge.
    always @(negedge clk) begin
        if (mon_on && out_stb) begin
            m_d.push_back(out_data);
            m_f.push_back({out_vs, out_ve, out_hs, out_he});
            m_t.push_back(cyc);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int pixv(int f, int l, int c, int salt);
        return (f * 331 + l * 97 + c * 29 + salt * 53 + 11) % 4096;
    endfunction

    // Present one pixel and wait for its handshake.
    task automatic send(input int p, input bit sof, input bit sol,
                        input bit eol, input bit eof);
        in_pix = PIX_W'(p); in_sof = sof; in_sol = sol; in_eol = eol; in_eof = eof;
        in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            stall_cnt++;
            @(negedge clk); #1;
        end
        @(negedge clk);
    endtask

    // Drive frames with continuous valid and compare every strobe with the model.
    task automatic run_frame(input string req_d, input int salt, input int nf,
                             input int nl, input int np, input bit dual,
                             input int pace, input int hb, input int vb);
        logic [31:0] e_d[$];
        logic [3:0]  e_f[$];
        int          e_g[$];
        bit prev_he = 0, prev_ve = 0;
        cfg_dual = dual; cfg_pace = 17'(pace); cfg_hblank = 8'(hb); cfg_vblank = 6'(vb);
        repeat (400) @(negedge clk);
        m_d.delete(); m_f.delete(); m_t.delete();
        for (int f = 0; f < nf; f++) begin
            for (int l = 0; l < nl; l++) begin
                int c = 0;
                while (c < np) begin
                    bit pair = dual && (c + 1 < np);
                    int last = pair ? c + 1 : c;
                    bit he = (last == np - 1);
                    bit ve = he && (l == nl - 1);
                    int g = (pace <= 1) ? 1 : pace;
                    if (pair) e_d.push_back({4'h0, 12'(pixv(f, l, c + 1, salt)), 4'h0, 12'(pixv(f, l, c, salt))});
                    else      e_d.push_back({16'h0, 4'h0, 12'(pixv(f, l, c, salt))});
                    e_f.push_back({(l == 0 && c == 0), ve, (c == 0), he});
                    if (prev_he) g = (g > hb + 1 + (prev_ve ? vb : 0)) ? g : hb + 1 + (prev_ve ? vb : 0);
                    if (pair && g < 2) g = 2;
                    e_g.push_back(g);
                    prev_he = he; prev_ve = ve;
                    c = last + 1;
                end
            end
        end
        mon_on = 1'b1;
        stall_cnt = 0;
        for (int f = 0; f < nf; f++)
            for (int l = 0; l < nl; l++)
                for (int c = 0; c < np; c++)
                    send(pixv(f, l, c, salt), (l == 0 && c == 0), (c == 0),
                         (c == np - 1), (c == np - 1 && l == nl - 1));
        in_valid = 1'b0; in_sof = 0; in_sol = 0; in_eol = 0; in_eof = 0;
        repeat (400) @(negedge clk);
        mon_on = 1'b0;
        chk(m_d.size() == e_d.size(), req_d, "strobe count", m_d.size(), e_d.size());
        for (int i = 0; i < e_d.size() && i < m_d.size(); i++) begin
            string rg;
            chk(m_d[i] == e_d[i], req_d, "data", m_d[i], e_d[i]);
            chk(m_d[i][15:12] == 4'h0 && m_d[i][31:28] == 4'h0, "R4", "lane padding", m_d[i], e_d[i]);
            chk(m_f[i] == e_f[i], "R5/R6", "markers vs,ve,hs,he", m_f[i], e_f[i]);
            if (i > 0) begin
                rg = (e_f[i-1][2]) ? "R9" : (e_f[i-1][0]) ? "R8" : "R7";
                chk(m_t[i] - m_t[i-1] == e_g[i], rg, "strobe gap", m_t[i] - m_t[i-1], e_g[i]);
            end
        end
    endtask

    task automatic t_reset();
        repeat (3) begin
            @(negedge clk);
            chk(!out_stb && !out_vs && !out_ve && !out_hs && !out_he && out_data == 0,
                "R1", "outputs in reset", {27'h0, out_stb, out_vs, out_ve, out_hs, out_he}, 0);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!out_stb && out_data == 0, "R1", "outputs after reset", out_data, 0);
        #1;
        chk(in_ready, "R1", "ready after reset", in_ready, 1);
    endtask

    task automatic t_single();   // R2, R5, R6, R8
        run_frame("R2", 1, 1, 2, 3, 0, 0, 2, 0);
    endtask

    task automatic t_pace();     // R7, R11
        run_frame("R2", 2, 1, 1, 4, 0, 5, 0, 0);
        chk(stall_cnt == 12, "R11", "ready-low cycles under spacing", stall_cnt, 12);
    endtask

    task automatic t_dual();     // R3
        run_frame("R3", 3, 1, 2, 4, 1, 1, 3, 0);
        run_frame("R3", 4, 1, 1, 6, 1, 4, 0, 0);
    endtask

    task automatic t_odd();      // R10
        run_frame("R10", 5, 1, 2, 3, 1, 3, 1, 0);
    endtask

    task automatic t_frames();   // R9, R5
        run_frame("R2", 6, 2, 2, 2, 0, 0, 2, 5);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_single();
        t_pace();
        t_dual();
        t_odd();
        t_frames();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule